// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control unit of a small 32-bit processor that takes several clock cycles per instruction. The processor runs a subset of a load/store instruction set. Every instruction runs through the same three steps. First the word at the program counter is fetched into the instruction register, and the program counter is advanced by one through the shared ALU. Then a decode cycle lets the register file present the two source operands. Finally one or more execute cycles do the instruction's work. The datapath, the memory and the ALU sit outside the block. The controller sees only the instruction register and the ALU zero flag. It drives the full set of register-transfer strobes and selects.

The machine is of Moore type. Every state carries one fixed control word, and the next state is chosen at the clock edge. Register-type instructions get one execute state for each function code, so the ALU operation is set by the state alone. An opcode or function code outside the supported set leaves decode straight back to fetch. A halt instruction parks the machine until reset. The block has no streaming data path, so every pin is a plain control or status line and there is no valid/ready handshake.

Top module: `mcc_ctrl_top`

## Requirements
- R1: A synchronous reset puts the machine in the fetch state. The fetch control word is on the outputs from the first clock edge with reset high, and it stays there until reset falls, from any state including halt.
- R2: In fetch the controller asserts PC address enable, memory read, IR load, PC load and PC select = 1 (ALU result). It sets ALU A select = 1 (PC), ALU B select = 2'b11 (constant one) and ALU op = 6'b000001 (add). All other outputs are 0.
- R3: The cycle after fetch is always decode, in which every output is 0.
- R4: At the end of decode the next state is chosen from opcode bits [31:26]. Opcode 0 is register type, with its function in bits [5:0]: 32 add, 34 subtract, 36 and, 37 or, 42 set-less-than. The other opcodes are 35 load, 43 store, 4 branch-if-equal, 8 add-immediate, 2 jump and 63 halt. Any other opcode, or any other function code under opcode 0, returns to fetch.
- R5: A register-type execute cycle sets A select = 0 (register A), B select = 2'b00 (register B), register write = 1, write-data select = 0 (ALU) and write-register select = 1 (rd). The one-hot ALU op is 000001 for add, 000010 for subtract, 000100 for and and 001000 for or. Set-less-than uses subtract, and the datapath forms the flag from the sign. The next state is fetch.
- R6: Add-immediate runs one cycle with A select = 0, B select = 2'b10 (sign-extended immediate), op add, register write = 1, write-data select = 0 and write-register select = 0 (rt). It then returns to fetch.
- R7: Branch-if-equal runs a compare cycle with A = 0, B = 2'b00 and op subtract. If the zero flag is 1 at the end of that cycle, a taken cycle follows with A = 1, B = 2'b10, op add, PC load = 1 and PC select = 1, and then fetch. If the flag is 0, the machine goes straight to fetch.
- R8: Load runs an address cycle with A = 0, B = 2'b10, op add, ALU address enable, memory read and MBR load. A write-back cycle follows with register write = 1, write-data select = 1 (MBR) and write-register select = 0. Then the machine returns to fetch.
- R9: Store runs one cycle with A = 0, B = 2'b10, op add, ALU address enable, register-B data drive and memory write. It then returns to fetch.
- R10: Jump runs one cycle with PC load = 1 and PC select = 0 (target field), all other outputs 0, and then returns to fetch.
- R11: Halt drives all outputs to 0 and holds its state on every edge until reset.
- R12: Memory read and memory write are never high together, and at most one of the two address-bus enables is high.
- R13: The ALU op output has at most one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_word | input | INSTR_W | Current instruction register contents |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_addr_en | output | 1 | Drive PC onto the memory address bus |
| alu_addr_en | output | 1 | Drive ALU result onto the memory address bus |
| regb_data_en | output | 1 | Drive register B onto the memory data bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Load instruction register |
| pc_ld | output | 1 | Load program counter |
| pc_sel | output | 1 | PC source: 1 ALU result, 0 target field |
| alu_a_sel | output | 1 | ALU A source: 1 PC, 0 register A |
| alu_b_sel | output | 2 | ALU B source: 00 reg B, 01 zero, 10 immediate, 11 one |
| alu_op | output | 6 | One-hot ALU operation |
| rf_we | output | 1 | Register file write enable |
| wd_sel | output | 1 | Write data: 1 MBR, 0 ALU result |
| wr_sel | output | 1 | Write register: 1 rd, 0 rt |
| mbr_ld | output | 1 | Load memory buffer register |

## Verification
The bench builds the controller with the default INSTR_W of 32. This is the only width at which the opcode and function fields land on the bit positions the dispatch rules name. With it every supported opcode, every register function and the rejected codes can be driven as real 32-bit instruction words. The zero flag is driven both ways at the end of a compare cycle, so both branch paths are reached. The halt state is held over several edges and then left through reset.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 6;
  localparam int BSEL_W  = 2;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE,
    S_EX_ADD, S_EX_SUB, S_EX_AND, S_EX_OR, S_EX_SLT,
    S_EX_ADDI, S_EX_CMP, S_EX_BTAKE,
    S_EX_LDADDR, S_EX_LDWB, S_EX_STORE, S_EX_JUMP, S_HALT
  } state_e;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_HALT  = 6'd63;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  localparam logic [ALUOP_W-1:0] ALU_ADD   = ALUOP_W'(1) << 0;
  localparam logic [ALUOP_W-1:0] ALU_SUB   = ALUOP_W'(1) << 1;
  localparam logic [ALUOP_W-1:0] ALU_AND   = ALUOP_W'(1) << 2;
  localparam logic [ALUOP_W-1:0] ALU_OR    = ALUOP_W'(1) << 3;
  localparam logic [ALUOP_W-1:0] ALU_PASSA = ALUOP_W'(1) << 4;
  localparam logic [ALUOP_W-1:0] ALU_PASSB = ALUOP_W'(1) << 5;

  localparam logic [BSEL_W-1:0] BSRC_REGB = 2'b00;
  localparam logic [BSEL_W-1:0] BSRC_ZERO = 2'b01;
  localparam logic [BSEL_W-1:0] BSRC_IMM  = 2'b10;
  localparam logic [BSEL_W-1:0] BSRC_ONE  = 2'b11;

  typedef struct packed {
    logic               pc_addr_en;
    logic               alu_addr_en;
    logic               regb_data_en;
    logic               mem_rd;
    logic               mem_wr;
    logic               ir_ld;
    logic               pc_ld;
    logic               pc_sel;
    logic               a_sel;
    logic [BSEL_W-1:0]  b_sel;
    logic [ALUOP_W-1:0] alu_op;
    logic               rf_we;
    logic               wd_sel;
    logic               wr_sel;
    logic               mbr_ld;
  } ctrl_word_t;
endpackage

// File: rtl/mcc_dispatch.sv
module mcc_dispatch
  import mcc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output state_e             target
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;
  logic             unused_mid;

  assign opc        = instr[INSTR_W-1:OPC_LSB];
  assign fn         = instr[FN_W-1:0];
  assign unused_mid = ^instr[OPC_LSB-1:FN_W];

  // R4: opcode (and function code for register type) picks the first execute state
  always_comb begin
    target = S_FETCH;
    case (opc)
      OPC_REG: begin
        case (fn)
          FN_ADD:  target = S_EX_ADD;
          FN_SUB:  target = S_EX_SUB;
          FN_AND:  target = S_EX_AND;
          FN_OR:   target = S_EX_OR;
          FN_SLT:  target = S_EX_SLT;
          default: target = S_FETCH;
        endcase
      end
      OPC_LOAD:  target = S_EX_LDADDR;
      OPC_STORE: target = S_EX_STORE;
      OPC_BEQ:   target = S_EX_CMP;
      OPC_ADDI:  target = S_EX_ADDI;
      OPC_JUMP:  target = S_EX_JUMP;
      OPC_HALT:  target = S_HALT;
      default:   target = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e target,
  input  logic   alu_zero,
  output state_e state
);
  state_e nxt;

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH:     nxt = S_DECODE;
      S_DECODE:    nxt = target;
      S_EX_CMP:    nxt = alu_zero ? S_EX_BTAKE : S_FETCH;
      S_EX_LDADDR: nxt = S_EX_LDWB;
      S_HALT:      nxt = S_HALT;
      default:     nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  // R1: reset lands in fetch
  a_r1_reset_fetch: assert property (@(posedge clk) rst |=> state == S_FETCH);
  // R3: fetch is always followed by decode
  a_r3_fetch_decode: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);
  // R7: compare with zero flag clear returns to fetch
  a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
    (state == S_EX_CMP && !alu_zero) |=> state == S_FETCH);
  // R8: load address cycle is followed by write-back
  a_r8_load_wb: assert property (@(posedge clk) disable iff (rst)
    state == S_EX_LDADDR |=> state == S_EX_LDWB);
  // R11: halt holds until reset
  a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
    state == S_HALT |=> state == S_HALT);
endmodule

// File: rtl/mcc_outgen.sv
module mcc_outgen
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  state_e     state,
  output ctrl_word_t cw
);
  always_comb begin
    cw = '0;
    case (state)
      S_FETCH: begin
        cw.pc_addr_en = 1'b1;
        cw.mem_rd     = 1'b1;
        cw.ir_ld      = 1'b1;
        cw.pc_ld      = 1'b1;
        cw.pc_sel     = 1'b1;
        cw.a_sel      = 1'b1;
        cw.b_sel      = BSRC_ONE;
        cw.alu_op     = ALU_ADD;
      end
      S_EX_ADD, S_EX_SUB, S_EX_AND, S_EX_OR, S_EX_SLT: begin
        cw.b_sel  = BSRC_REGB;
        cw.rf_we  = 1'b1;
        cw.wr_sel = 1'b1;
        case (state)
          S_EX_ADD: cw.alu_op = ALU_ADD;
          S_EX_AND: cw.alu_op = ALU_AND;
          S_EX_OR:  cw.alu_op = ALU_OR;
          default:  cw.alu_op = ALU_SUB;
        endcase
      end
      S_EX_ADDI: begin
        cw.b_sel  = BSRC_IMM;
        cw.alu_op = ALU_ADD;
        cw.rf_we  = 1'b1;
      end
      S_EX_CMP: begin
        cw.b_sel  = BSRC_REGB;
        cw.alu_op = ALU_SUB;
      end
      S_EX_BTAKE: begin
        cw.a_sel  = 1'b1;
        cw.b_sel  = BSRC_IMM;
        cw.alu_op = ALU_ADD;
        cw.pc_ld  = 1'b1;
        cw.pc_sel = 1'b1;
      end
      S_EX_LDADDR: begin
        cw.b_sel       = BSRC_IMM;
        cw.alu_op      = ALU_ADD;
        cw.alu_addr_en = 1'b1;
        cw.mem_rd      = 1'b1;
        cw.mbr_ld      = 1'b1;
      end
      S_EX_LDWB: begin
        cw.rf_we  = 1'b1;
        cw.wd_sel = 1'b1;
      end
      S_EX_STORE: begin
        cw.b_sel        = BSRC_IMM;
        cw.alu_op       = ALU_ADD;
        cw.alu_addr_en  = 1'b1;
        cw.regb_data_en = 1'b1;
        cw.mem_wr       = 1'b1;
      end
      S_EX_JUMP: begin
        cw.pc_ld = 1'b1;
      end
      default: cw = '0;
    endcase
  end

  // R12: no read/write overlap, single address-bus driver
  a_r12_rw_excl: assert property (@(posedge clk) disable iff (rst)
    !(cw.mem_rd && cw.mem_wr));
  a_r12_addr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.pc_addr_en, cw.alu_addr_en}));
  // R13: ALU operation stays one-hot or idle
  a_r13_op_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cw.alu_op));
endmodule

// File: rtl/mcc_ctrl_top.sv
module mcc_ctrl_top
  import mcc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] ir_word,
  input  logic               alu_zero,
  output logic               pc_addr_en,
  output logic               alu_addr_en,
  output logic               regb_data_en,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_ld,
  output logic               pc_ld,
  output logic               pc_sel,
  output logic               alu_a_sel,
  output logic [BSEL_W-1:0]  alu_b_sel,
  output logic [ALUOP_W-1:0] alu_op,
  output logic               rf_we,
  output logic               wd_sel,
  output logic               wr_sel,
  output logic               mbr_ld
);
  state_e     target;
  state_e     state;
  ctrl_word_t cw;

  mcc_dispatch #(.INSTR_W(INSTR_W)) u_dispatch (
    .instr  (ir_word),
    .target (target)
  );

  mcc_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .target   (target),
    .alu_zero (alu_zero),
    .state    (state)
  );

  mcc_outgen u_out (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .cw    (cw)
  );

  assign pc_addr_en   = cw.pc_addr_en;
  assign alu_addr_en  = cw.alu_addr_en;
  assign regb_data_en = cw.regb_data_en;
  assign mem_rd       = cw.mem_rd;
  assign mem_wr       = cw.mem_wr;
  assign ir_ld        = cw.ir_ld;
  assign pc_ld        = cw.pc_ld;
  assign pc_sel       = cw.pc_sel;
  assign alu_a_sel    = cw.a_sel;
  assign alu_b_sel    = cw.b_sel;
  assign alu_op       = cw.alu_op;
  assign rf_we        = cw.rf_we;
  assign wd_sel       = cw.wd_sel;
  assign wr_sel       = cw.wr_sel;
  assign mbr_ld       = cw.mbr_ld;

  // R3: an instruction-register load is followed by a quiet decode cycle
  a_r3_decode_quiet: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (!ir_ld && !pc_ld && !rf_we && !mem_wr));
endmodule

// File: tb/mcc_ctrl_top_bench.sv
module mcc_ctrl_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ir_word = '0;
  logic        alu_zero = 1'b0;
  logic        pc_addr_en, alu_addr_en, regb_data_en, mem_rd, mem_wr;
  logic        ir_ld, pc_ld, pc_sel, alu_a_sel, rf_we, wd_sel, wr_sel, mbr_ld;
  logic [1:0]  alu_b_sel;
  logic [5:0]  alu_op;
  logic [20:0] act;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mcc_ctrl_top u_mcc_ctrl_top (
    .clk(clk), .rst(rst), .ir_word(ir_word), .alu_zero(alu_zero),
    .pc_addr_en(pc_addr_en), .alu_addr_en(alu_addr_en), .regb_data_en(regb_data_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .pc_ld(pc_ld), .pc_sel(pc_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .rf_we(rf_we),
    .wd_sel(wd_sel), .wr_sel(wr_sel), .mbr_ld(mbr_ld)
  );

  assign act = {pc_addr_en, alu_addr_en, regb_data_en, mem_rd, mem_wr, ir_ld, pc_ld,
                pc_sel, alu_a_sel, alu_b_sel, alu_op, rf_we, wd_sel, wr_sel, mbr_ld};

  function automatic logic [20:0] cw(input logic pa, aa, rb, mr, mw, il, pl, ps, as,
                                     input logic [1:0] bs, input logic [5:0] op,
                                     input logic we, ds, rs, mb);
    return {pa, aa, rb, mr, mw, il, pl, ps, as, bs, op, we, ds, rs, mb};
  endfunction

  localparam logic [5:0] OP_ADD = 6'b000001, OP_SUB = 6'b000010,
                         OP_AND = 6'b000100, OP_OR  = 6'b001000;

  logic [20:0] w_fetch, w_idle, w_addi, w_cmp, w_btake, w_ldaddr, w_ldwb, w_store, w_jump;
  initial begin
    w_fetch  = cw(1,0,0,1,0,1,1,1,1,2'b11,OP_ADD,0,0,0,0);
    w_idle   = '0;
    w_addi   = cw(0,0,0,0,0,0,0,0,0,2'b10,OP_ADD,1,0,0,0);
    w_cmp    = cw(0,0,0,0,0,0,0,0,0,2'b00,OP_SUB,0,0,0,0);
    w_btake  = cw(0,0,0,0,0,0,1,1,1,2'b10,OP_ADD,0,0,0,0);
    w_ldaddr = cw(0,1,0,1,0,0,0,0,0,2'b10,OP_ADD,0,0,0,1);
    w_ldwb   = cw(0,0,0,0,0,0,0,0,0,2'b00,6'd0,1,1,0,0);
    w_store  = cw(0,1,1,0,1,0,0,0,0,2'b10,OP_ADD,0,0,0,0);
    w_jump   = cw(0,0,0,0,0,0,1,0,0,2'b00,6'd0,0,0,0,0);
  end

  function automatic logic [20:0] w_reg(input logic [5:0] op);
    return cw(0,0,0,0,0,0,0,0,0,2'b00,op,1,0,1,0);
  endfunction

  function automatic logic [31:0] rtype(input logic [5:0] fn);
    return {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] opc);
    return {opc, 5'd1, 5'd2, 16'h0004};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_w(input string tag, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // from a fetch cycle: check fetch and decode, finish positioned on first execute cycle
  task automatic issue(input logic [31:0] instr, input string tag);
    expect_w({tag, " R2 fetch word"}, w_fetch);
    ir_word = instr;
    step();
    expect_w({tag, " R3 decode word"}, w_idle);
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    expect_w("R1 fetch word under reset", w_fetch);
    step();
    expect_w("R1 fetch word held in reset", w_fetch);
    rst = 1'b0;
  endtask

  task automatic t_rop(input logic [5:0] fn, input logic [5:0] op, input string tag);
    issue(rtype(fn), tag);
    expect_w({tag, " R5 register execute"}, w_reg(op));
    step();
  endtask

  task automatic t_addi();
    issue(itype(6'd8), "addi");
    expect_w("R6 add-immediate execute", w_addi);
    step();
  endtask

  task automatic t_beq(input logic z);
    issue(itype(6'd4), "beq");
    expect_w("R7 compare word", w_cmp);
    alu_zero = z;
    step();
    alu_zero = 1'b0;
    if (z) begin
      expect_w("R7 taken word", w_btake);
      step();
    end
    expect_w("R7 back to fetch after branch", w_fetch);
  endtask

  task automatic t_load();
    issue(itype(6'd35), "load");
    expect_w("R8 load address word", w_ldaddr);
    step();
    expect_w("R8 load write-back word", w_ldwb);
    step();
  endtask

  task automatic t_store();
    issue(itype(6'd43), "store");
    expect_w("R9 store word", w_store);
    checks++;
    if (mem_rd && mem_wr) begin
      errors++;
      $display("FAIL R12 rd/wr overlap actual=%b%b expected=01", mem_rd, mem_wr);
    end
    step();
  endtask

  task automatic t_jump();
    issue({6'd2, 26'h0000123}, "jump");
    expect_w("R10 jump word", w_jump);
    step();
  endtask

  task automatic t_bad();
    issue(itype(6'd17), "bad opcode");
    expect_w("R4 unknown opcode returns to fetch", w_fetch);
    issue(rtype(6'd0), "bad funct");
    expect_w("R4 unknown function returns to fetch", w_fetch);
  endtask

  task automatic t_halt();
    issue(itype(6'd63), "halt");
    for (int i = 0; i < 5; i++) begin
      expect_w("R11 halt holds", w_idle);
      step();
    end
    ir_word = rtype(6'd32);
    expect_w("R11 halt still held", w_idle);
    rst = 1'b1;
    step();
    expect_w("R1 reset leaves halt", w_fetch);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #1;
    t_reset();
    t_rop(6'd32, OP_ADD, "add");
    t_rop(6'd34, OP_SUB, "sub");
    t_rop(6'd36, OP_AND, "and");
    t_rop(6'd37, OP_OR,  "or");
    t_rop(6'd42, OP_SUB, "slt");
    t_addi();
    t_beq(1'b1);
    t_beq(1'b0);
    t_load();
    t_store();
    t_jump();
    t_bad();
    expect_w("R2 fetch after rejected codes", w_fetch);
    t_halt();
    t_rop(6'd32, OP_ADD, "add after halt");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule